// File: doc/BRIEF.md
# Event Queue Ring Writer

This block appends interrupt event records to a ring buffer that lives in system memory. Each accepted event carries a 31-bit data word. The block turns that word into a 32-bit ring entry and writes it as one beat over a request/acknowledge memory port. The write goes to the slot selected by the queue's current write index. When the memory acknowledges the write, the block advances the write index.

The top bit of every entry holds a generation flag. The flag inverts each time the write index wraps back to slot zero. A consumer can therefore tell fresh entries from stale ones without sharing a read pointer with the writer.

The descriptor state is held in registers inside the block: a 60-bit base address, a size code, the write index and the generation flag. A load port fills these registers while the block is idle. The updated index and generation flag are driven out continuously. One write is in flight at a time, and new events are held back until it completes.

Top module: `evq_ring_writer`

## Requirements
- R1: After a synchronous reset, the write index is 0, the generation flag is 0, busy is 0, mem_req is 0 and ev_ready is 1.
- R2: The write address equals base + 4 × index, truncated to 60 bits.
- R3: The entry is {generation flag in bit 31, event data in bits 30:0}. It is placed on mem_wdata in big-endian byte order: entry bits 31:24 go on mem_wdata[7:0], bits 23:16 on mem_wdata[15:8], bits 15:8 on mem_wdata[23:16], and bits 7:0 on mem_wdata[31:24].
- R4: mem_req rises in the cycle after an event is accepted (ev_valid and ev_ready both high). mem_addr and mem_wdata then hold steady until the cycle in which mem_ack or mem_err is seen.
- R5: busy is high from the accepting edge until the response edge. ev_ready is low whenever busy is high.
- R6: A write that is acknowledged without an error advances the index by one, modulo a ring of 2^(size code + 10) entries. The new index is visible in the cycle after the response.
- R7: The generation flag inverts exactly when an advance takes the index to 0. Ring length follows the size code: 1024 entries for code 0, 4096 entries for code 2.
- R8: If mem_err is high in the response cycle, the index and generation flag stay unchanged. This holds even if mem_ack is also high. err_o pulses for the single cycle after the response.
- R9: While idle, ld_en loads the base, size code, generation flag and index in one cycle. The index is masked to the ring length of the new size code. ev_ready is low during a cycle in which ld_en is high.
- R10: ld_en is ignored while busy. The in-flight write still commits against the old descriptor, and later writes use the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load descriptor registers (honoured only when idle) |
| ld_base | input | 60 | Queue base address to load |
| ld_qsize | input | 4 | Size code to load; ring holds 2^(code+10) entries |
| ld_index | input | 25 | Write index to load |
| ld_gen | input | 1 | Generation flag to load |
| ev_valid | input | 1 | Event present |
| ev_data | input | 31 | Event data word |
| ev_ready | output | 1 | Event can be accepted this cycle |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 60 | Byte address of the entry |
| mem_wdata | output | 32 | Entry in big-endian byte order |
| mem_ack | input | 1 | Memory write completed |
| mem_err | input | 1 | Memory write failed |
| busy | output | 1 | A write is in flight |
| err_o | output | 1 | One-cycle pulse after a failed write |
| desc_index | output | 25 | Current write index |
| desc_gen | output | 1 | Current generation flag |

## Verification
A request is due one cycle after the accepting edge, so the bench checks mem_req and ev_ready at the falling edge that follows acceptance. The updated index, generation flag and err_o are due one cycle after the edge that sees the response. The bench waits at falling edges until busy drops, then compares these outputs against its own model. Address and data are due in the response cycle. A monitor compares them against a queue of expected entries 1 ns after the falling edge on which the memory model raises mem_ack or mem_err. The memory model's response latency is varied so that these positions are exercised at several distances.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int unsigned EVQ_MIN_LOG2    = 10;
  localparam int unsigned EVQ_ENTRY_BYTES = 4;

  typedef enum logic {
    WR_IDLE = 1'b0,
    WR_WAIT = 1'b1
  } wr_state_e;
endpackage

// File: rtl/evq_desc_regs.sv
module evq_desc_regs
  import evq_pkg::*;
#(
  parameter int ADDR_W  = 60,
  parameter int QSIZE_W = 4,
  parameter int IDX_W   = 25
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_take,
  input  logic [ADDR_W-1:0]  ld_base,
  input  logic [QSIZE_W-1:0] ld_qsize,
  input  logic [IDX_W-1:0]   ld_index,
  input  logic               ld_gen,
  input  logic               commit,
  output logic [ADDR_W-1:0]  base_q,
  output logic [IDX_W-1:0]   idx_q,
  output logic               gen_q
);
  logic [QSIZE_W-1:0] qsize_q;
  logic [IDX_W-1:0]   ring_mask;
  logic [IDX_W-1:0]   load_mask;
  logic [IDX_W-1:0]   idx_next;
  logic               wraps;

  // Per-bit masks: bit i is kept when i < code + minimum log2 ring size.
  for (genvar gi = 0; gi < IDX_W; gi++) begin : g_mask
    assign ring_mask[gi] = (gi < int'(qsize_q) + int'(EVQ_MIN_LOG2));
    assign load_mask[gi] = (gi < int'(ld_qsize) + int'(EVQ_MIN_LOG2));
  end

  assign idx_next = (idx_q + IDX_W'(1)) & ring_mask;
  assign wraps    = (idx_next == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      qsize_q <= '0;
      idx_q   <= '0;
      gen_q   <= 1'b0;
    end else if (ld_take) begin
      base_q  <= ld_base;
      qsize_q <= ld_qsize;
      idx_q   <= ld_index & load_mask;
      gen_q   <= ld_gen;
    end else if (commit) begin
      idx_q <= idx_next;
      if (wraps) gen_q <= ~gen_q;
    end
  end
endmodule

// File: rtl/evq_entry_fmt.sv
module evq_entry_fmt
  import evq_pkg::*;
#(
  parameter int ADDR_W = 60,
  parameter int IDX_W  = 25,
  parameter int DATA_W = 31,
  localparam int ENTRY_W = DATA_W + 1
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [IDX_W-1:0]   idx,
  input  logic               gen,
  input  logic [DATA_W-1:0]  data,
  output logic [ADDR_W-1:0]  addr,
  output logic [ENTRY_W-1:0] wdata
);
  localparam int NBYTES = ENTRY_W / 8;
  localparam int SHIFT  = $clog2(EVQ_ENTRY_BYTES);

  logic [ENTRY_W-1:0] entry;
  logic [ADDR_W-1:0]  offset;

  assign entry  = {gen, data};
  assign offset = ADDR_W'({idx, {SHIFT{1'b0}}});
  assign addr   = base + offset;

  // Most significant byte goes to the lowest-address lane.
  for (genvar gb = 0; gb < NBYTES; gb++) begin : g_lane
    assign wdata[8*gb +: 8] = entry[8*(NBYTES-1-gb) +: 8];
  end
endmodule

// File: rtl/evq_wr_ctrl.sv
module evq_wr_ctrl
  import evq_pkg::*;
#(
  parameter int ADDR_W  = 60,
  parameter int ENTRY_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_fire,
  input  logic [ADDR_W-1:0]  nxt_addr,
  input  logic [ENTRY_W-1:0] nxt_wdata,
  input  logic               mem_ack,
  input  logic               mem_err,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [ENTRY_W-1:0] mem_wdata,
  output logic               busy,
  output logic               err_o,
  output logic               commit
);
  wr_state_e state;

  assign mem_req = (state == WR_WAIT);
  assign busy    = (state == WR_WAIT);
  assign commit  = (state == WR_WAIT) && mem_ack && !mem_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= WR_IDLE;
      mem_addr  <= '0;
      mem_wdata <= '0;
      err_o     <= 1'b0;
    end else begin
      err_o <= 1'b0;
      unique case (state)
        WR_IDLE: begin
          if (ev_fire) begin
            state     <= WR_WAIT;
            mem_addr  <= nxt_addr;
            mem_wdata <= nxt_wdata;
          end
        end
        WR_WAIT: begin
          if (mem_err) begin
            state <= WR_IDLE;
            err_o <= 1'b1;
          end else if (mem_ack) begin
            state <= WR_IDLE;
          end
        end
        default: state <= WR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evq_ring_writer.sv
module evq_ring_writer
  import evq_pkg::*;
#(
  parameter int ADDR_W  = 60,
  parameter int QSIZE_W = 4,
  parameter int DATA_W  = 31,
  localparam int IDX_W   = (1 << QSIZE_W) - 1 + int'(EVQ_MIN_LOG2),
  localparam int ENTRY_W = DATA_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_en,
  input  logic [ADDR_W-1:0]  ld_base,
  input  logic [QSIZE_W-1:0] ld_qsize,
  input  logic [IDX_W-1:0]   ld_index,
  input  logic               ld_gen,
  input  logic               ev_valid,
  input  logic [DATA_W-1:0]  ev_data,
  output logic               ev_ready,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [ENTRY_W-1:0] mem_wdata,
  input  logic               mem_ack,
  input  logic               mem_err,
  output logic               busy,
  output logic               err_o,
  output logic [IDX_W-1:0]   desc_index,
  output logic               desc_gen
);
  logic [ADDR_W-1:0]  base_q;
  logic [ADDR_W-1:0]  nxt_addr;
  logic [ENTRY_W-1:0] nxt_wdata;
  logic               commit;
  logic               ld_take;
  logic               ev_fire;

  assign ev_ready = !busy && !ld_en;
  assign ev_fire  = ev_valid && ev_ready;
  assign ld_take  = ld_en && !busy;

  evq_desc_regs #(
    .ADDR_W (ADDR_W),
    .QSIZE_W(QSIZE_W),
    .IDX_W  (IDX_W)
  ) u_desc (
    .clk     (clk),
    .rst     (rst),
    .ld_take (ld_take),
    .ld_base (ld_base),
    .ld_qsize(ld_qsize),
    .ld_index(ld_index),
    .ld_gen  (ld_gen),
    .commit  (commit),
    .base_q  (base_q),
    .idx_q   (desc_index),
    .gen_q   (desc_gen)
  );

  evq_entry_fmt #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W),
    .DATA_W(DATA_W)
  ) u_fmt (
    .base (base_q),
    .idx  (desc_index),
    .gen  (desc_gen),
    .data (ev_data),
    .addr (nxt_addr),
    .wdata(nxt_wdata)
  );

  evq_wr_ctrl #(
    .ADDR_W (ADDR_W),
    .ENTRY_W(ENTRY_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ev_fire  (ev_fire),
    .nxt_addr (nxt_addr),
    .nxt_wdata(nxt_wdata),
    .mem_ack  (mem_ack),
    .mem_err  (mem_err),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .busy     (busy),
    .err_o    (err_o),
    .commit   (commit)
  );
endmodule

// File: rtl/evq_ring_writer_chk.sv
module evq_ring_writer_chk #(
  parameter int ADDR_W  = 60,
  parameter int IDX_W   = 25,
  parameter int ENTRY_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               ld_en,
  input logic               ev_valid,
  input logic               ev_ready,
  input logic               mem_req,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [ENTRY_W-1:0] mem_wdata,
  input logic               mem_ack,
  input logic               mem_err,
  input logic               busy,
  input logic               err_o,
  input logic [IDX_W-1:0]   desc_index,
  input logic               desc_gen
);
  AST_ACCEPT_REQ: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_ready) |=> (mem_req && busy)); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata))); // R4

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ev_ready); // R5

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !mem_err) |=> (desc_index != $past(desc_index))); // R6

  AST_GEN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !mem_err) |=> ((desc_gen != $past(desc_gen)) == (desc_index == '0))); // R7

  AST_DESC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(mem_req && mem_ack && !mem_err) && !(ld_en && !busy)) |=> ($stable(desc_index) && $stable(desc_gen))); // R8

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(mem_req && mem_err)); // R8
endmodule

bind evq_ring_writer evq_ring_writer_chk #(
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W),
  .ENTRY_W(ENTRY_W)
) u_chk (.*);

// File: tb/evq_ring_writer_bench.sv
`timescale 1ns/1ps
module evq_ring_writer_bench;
  localparam int ADDR_W  = 60;
  localparam int QSIZE_W = 4;
  localparam int DATA_W  = 31;
  localparam int IDX_W   = 25;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [31:0]       data;
  } exp_t;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               ld_en = 1'b0;
  logic [ADDR_W-1:0]  ld_base = '0;
  logic [QSIZE_W-1:0] ld_qsize = '0;
  logic [IDX_W-1:0]   ld_index = '0;
  logic               ld_gen = 1'b0;
  logic               ev_valid = 1'b0;
  logic [DATA_W-1:0]  ev_data = '0;
  logic               ev_ready;
  logic               mem_req;
  logic [ADDR_W-1:0]  mem_addr;
  logic [31:0]        mem_wdata;
  logic               mem_ack = 1'b0;
  logic               mem_err = 1'b0;
  logic               busy;
  logic               err_o;
  logic [IDX_W-1:0]   desc_index;
  logic               desc_gen;

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  int wcnt   = 0;
  bit err_mode = 1'b0;
  bit finished = 1'b0;

  exp_t sb[$];

  logic [ADDR_W-1:0]  m_base  = '0;
  logic [QSIZE_W-1:0] m_qsize = '0;
  logic [IDX_W-1:0]   m_idx   = '0;
  logic               m_gen   = 1'b0;

  always #4 clk = ~clk;

  evq_ring_writer u_evq_ring_writer (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_base(ld_base), .ld_qsize(ld_qsize),
    .ld_index(ld_index), .ld_gen(ld_gen), .ev_valid(ev_valid), .ev_data(ev_data),
    .ev_ready(ev_ready), .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .busy(busy), .err_o(err_o),
    .desc_index(desc_index), .desc_gen(desc_gen)
  );

  function automatic logic [IDX_W-1:0] ring_mask(input logic [QSIZE_W-1:0] q);
    return IDX_W'((64'd1 << (int'(q) + 10)) - 64'd1);
  endfunction

  function automatic logic [31:0] to_be(input logic [31:0] e);
    return {e[7:0], e[15:8], e[23:16], e[31:24]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory model: answers after lat falling edges of an open request.
  always @(negedge clk) begin
    mem_ack = 1'b0;
    mem_err = 1'b0;
    if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        mem_err = err_mode;
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end else begin
      wcnt = 0;
    end
  end

  // Scoreboard monitor: compares address and data in the response cycle.
  always @(negedge clk) begin
    #1;
    if (mem_req && (mem_ack || mem_err)) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R4", "unexpected write", 64'(mem_addr), 64'd0);
      end else begin
        exp_t x;
        x = sb.pop_front();
        chk(mem_addr == x.addr, "R2", "address", 64'(mem_addr), 64'(x.addr));
        chk(mem_wdata == x.data, "R3", "entry data", 64'(mem_wdata), 64'(x.data));
      end
    end
  end

  task automatic push_exp(input logic [DATA_W-1:0] d);
    exp_t x;
    x.addr = m_base + (ADDR_W'(m_idx) << 2);
    x.data = to_be({m_gen, d});
    sb.push_back(x);
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 100) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic after_resp(input bit e);
    chk(err_o == e, "R8", "err pulse", 64'(err_o), 64'(e));
    if (!e) begin
      m_idx = (m_idx + 1'b1) & ring_mask(m_qsize);
      if (m_idx == '0) m_gen = ~m_gen;
    end
    chk(desc_index == m_idx, "R6", "index", 64'(desc_index), 64'(m_idx));
    chk(desc_gen == m_gen, "R7", "generation", 64'(desc_gen), 64'(m_gen));
  endtask

  task automatic send(input logic [DATA_W-1:0] d, input bit e);
    push_exp(d);
    err_mode = e;
    @(negedge clk);
    chk(ev_ready == 1'b1, "R5", "ready when idle", 64'(ev_ready), 64'd1);
    ev_valid = 1'b1;
    ev_data  = d;
    @(negedge clk);
    ev_valid = 1'b0;
    chk(mem_req == 1'b1, "R4", "request after accept", 64'(mem_req), 64'd1);
    chk(ev_ready == 1'b0, "R5", "stall while busy", 64'(ev_ready), 64'd0);
    wait_idle();
    after_resp(e);
    err_mode = 1'b0;
  endtask

  task automatic load(input logic [ADDR_W-1:0] b, input logic [QSIZE_W-1:0] q,
                      input logic [IDX_W-1:0] i, input logic g);
    @(negedge clk);
    ld_en = 1'b1; ld_base = b; ld_qsize = q; ld_index = i; ld_gen = g;
    #1;
    chk(ev_ready == 1'b0, "R9", "ready low during load", 64'(ev_ready), 64'd0);
    @(negedge clk);
    ld_en = 1'b0;
    m_base = b; m_qsize = q; m_idx = i & ring_mask(q); m_gen = g;
    chk(desc_index == m_idx, "R9", "loaded index", 64'(desc_index), 64'(m_idx));
    chk(desc_gen == m_gen, "R9", "loaded generation", 64'(desc_gen), 64'(m_gen));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(desc_index == '0, "R1", "reset index", 64'(desc_index), 64'd0);
    chk(desc_gen == 1'b0, "R1", "reset gen", 64'(desc_gen), 64'd0);
    chk(busy == 1'b0, "R1", "reset busy", 64'(busy), 64'd0);
    chk(mem_req == 1'b0, "R1", "reset req", 64'(mem_req), 64'd0);
    chk(ev_ready == 1'b1, "R1", "reset ready", 64'(ev_ready), 64'd1);

    // Basic writes with several latencies and data patterns (R2 R3 R4 R6)
    send(31'h0123_4567, 1'b0);
    load(60'h123_4567_89AB_C000, 4'd1, 25'd5, 1'b1);
    lat = 3;
    send(31'h7FFF_FFFF, 1'b0);
    lat = 0;
    send(31'h0000_0000, 1'b0);
    lat = 1;
    send(31'h2A5A_5A5A, 1'b0);

    // R8: error leaves descriptor untouched, also with ack high
    send(31'h1111_2222, 1'b1);
    send(31'h3333_4444, 1'b0);

    // R7: wrap at 1024 entries for size code 0
    lat = 0;
    load(60'h0_0000_0010_0000, 4'd0, 25'd1022, 1'b0);
    send(31'h0000_0001, 1'b0);
    send(31'h0000_0002, 1'b0);
    send(31'h0000_0003, 1'b0);
    load(60'h0_0000_0010_0000, 4'd0, 25'd1023, 1'b1);
    send(31'h0000_0004, 1'b0);

    // R7: wrap at 4096 entries for size code 2
    load(60'h0_0000_0020_0000, 4'd2, 25'd4095, 1'b0);
    send(31'h5555_5555, 1'b0);

    // R9: loaded index is masked to the ring length
    load(60'h0_0000_0030_0000, 4'd0, 25'd2000, 1'b0);
    chk(desc_index == 25'd976, "R9", "masked index", 64'(desc_index), 64'd976);

    // R2: address wraps modulo 2^60
    load(60'hFFF_FFFF_FFFF_FFF8, 4'd0, 25'd3, 1'b0);
    send(31'h0BAD_F00D, 1'b0);

    // R10: load attempt while busy is ignored
    load(60'h0_0000_0040_0000, 4'd1, 25'd100, 1'b0);
    lat = 4;
    push_exp(31'h4444_0000);
    @(negedge clk);
    ev_valid = 1'b1; ev_data = 31'h4444_0000;
    @(negedge clk);
    ev_valid = 1'b0;
    ld_en = 1'b1; ld_base = 60'h0_0000_0099_0000; ld_qsize = 4'd3;
    ld_index = 25'd7; ld_gen = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
    wait_idle();
    chk(desc_index == 25'd101, "R10", "index after ignored load", 64'(desc_index), 64'd101);
    after_resp(1'b0);
    lat = 0;
    send(31'h4444_0001, 1'b0);

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R4", "all expected writes seen", 64'(sb.size()), 64'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule